// File: doc/BRIEF.md
# Multiphase Switching Clock Generator

This block derives four per-channel switch-start pulses for a set of buck converter channels, plus a square synchronization clock, from a single shared period counter clocked by the system clock. The switching period is a configurable count of system clocks. Channel 1 is the phase reference. Channels 2, 3 and 4 each start a quarter-period multiple later than channel 1. Any channel may instead run at half the master rate.

Configuration arrives on parallel ports and is captured into a shadow bank when a write strobe is high. The shadow bank is copied into the working settings only at the end of a switching period, or at any time while the generator is stopped, so a period never mixes two settings. A paralleling option ties channels 1 and 2 together at half a period apart, whatever channel 2's own field holds. The synchronization clock rises at the start of each period. Channel 1 starts a little later, so that a second device following the clock sees its edge ahead of the local switching.

Top module: `mpc_clkgen`

## Requirements
- R1: While `run_en` is low, and in every cycle after reset until the generator has been enabled, `chan_start` and `sync_out` are all zero.
- R2: The working period N is the written period value with its two low bits cleared, raised to 8 if the result is below 8. The synchronization clock and every undivided channel repeat every N cycles.
- R3: `sync_out` is high for cycles 0 to N/2-1 of each period and low for the rest. Cycle 0 is the first cycle after `run_en` is sampled high, and the first cycle after each period end.
- R4: Channel 1 (`chan_start[0]`) pulses in period cycle L = floor(5*N/32), which is about 15% of the period after the rise of `sync_out`.
- R5: Channels 2, 3 and 4 (`chan_start[1..3]`) pulse in period cycle L + q*N/4. Here q is their 2-bit phase field: 0 for 0°, 1 for 90°, 2 for 180°, 3 for 270°.
- R6: After reset, with no write, the phase fields hold q=2 for channel 2, q=1 for channel 3 and q=3 for channel 4. This places channel 4 180° after channel 3. The period holds 40.
- R7: With `cfg_parallel` set, channel 2 pulses with q=2 regardless of `cfg_phase2`.
- R8: A channel whose `cfg_half_rate` bit is set pulses only in even-numbered periods. The first period after enabling is period 0.
- R9: A write made while running leaves the current period unchanged and takes effect from the next period boundary.
- R10: Dropping `run_en` clears the outputs from the next cycle. Re-enabling restarts at period 0, cycle 0.
- R11: Every start pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Global enable; low stops and clears the counter |
| cfg_wr | input | 1 | Captures all cfg_* ports into the shadow bank |
| cfg_period | input | CNT_W | Requested period in system clocks |
| cfg_phase2 | input | 2 | Phase field of channel 2 (quarter periods) |
| cfg_phase3 | input | 2 | Phase field of channel 3 |
| cfg_phase4 | input | 2 | Phase field of channel 4 |
| cfg_half_rate | input | 4 | Per-channel half-rate select, bit 0 is channel 1 |
| cfg_parallel | input | 1 | Ties channel 2 at 180° to channel 1 |
| chan_start | output | 4 | One-cycle start pulse per channel, bit 0 is channel 1 |
| sync_out | output | 1 | 50% duty synchronization clock |

## Verification
The checker relies on the working period changing only at a period end, where `sync_out` is already low. This lets it compare the length of each high phase with half the period in force. It also relies on N being at least 8, so that a start pulse can never repeat in the next cycle and channel 1's slot always falls inside the high half. The stimulus changes configuration only through the strobe, either while stopped or at least two cycles before a period end. It covers every legal phase combination, every half-rate mask and several raw period values that need rounding or raising.

// File: rtl/mpc_pkg.sv
// Shared types and constants for the multiphase clock generator.
// Assumes four channels, with channel 1 as the fixed phase reference.
package mpc_pkg;
    typedef logic [1:0] quad_t;

    localparam int    NUM_CH   = 4;
    localparam int    MIN_PER  = 8;
    localparam quad_t QUAD_0   = 2'd0;
    localparam quad_t QUAD_90  = 2'd1;
    localparam quad_t QUAD_180 = 2'd2;
    localparam quad_t QUAD_270 = 2'd3;

    localparam quad_t RST_PH2  = QUAD_180;
    localparam quad_t RST_PH3  = QUAD_90;
    localparam quad_t RST_PH4  = QUAD_270;
endpackage

// File: rtl/mpc_cfg_regs.sv
// Configuration storage: a shadow bank written by strobe, and a working bank
// copied from it on `load`. Assumes `load` is high only at period ends or while
// stopped. The period is made legal (multiple of 4, at least MIN_PER) at capture.
module mpc_cfg_regs
    import mpc_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int DEF_PERIOD = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CNT_W-1:0]  cfg_period,
    input  quad_t             cfg_phase2,
    input  quad_t             cfg_phase3,
    input  quad_t             cfg_phase4,
    input  logic [NUM_CH-1:0] cfg_half_rate,
    input  logic              cfg_parallel,
    input  logic              load,
    output logic [CNT_W-1:0]  act_period,
    output quad_t             act_ph2,
    output quad_t             act_ph3,
    output quad_t             act_ph4,
    output logic [NUM_CH-1:0] act_half,
    output logic              act_par
);
    localparam int DEF_AL = ((DEF_PERIOD / 4) * 4 < MIN_PER) ? MIN_PER : (DEF_PERIOD / 4) * 4;
    localparam logic [CNT_W-1:0] RST_PERIOD = CNT_W'(DEF_AL);

    logic [CNT_W-1:0]  sh_period;
    quad_t             sh_ph2, sh_ph3, sh_ph4;
    logic [NUM_CH-1:0] sh_half;
    logic              sh_par;
    logic [CNT_W-1:0]  legal_period;

    // Round the requested period down to a quarter multiple and raise it to the floor.
    always_comb begin
        legal_period = {cfg_period[CNT_W-1:2], 2'b00};
        if (legal_period < CNT_W'(MIN_PER)) begin
            legal_period = CNT_W'(MIN_PER);
        end
    end

    // Shadow bank: captures the ports on the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_period <= RST_PERIOD;
            sh_ph2    <= RST_PH2;
            sh_ph3    <= RST_PH3;
            sh_ph4    <= RST_PH4;
            sh_half   <= '0;
            sh_par    <= 1'b0;
        end else if (cfg_wr) begin
            sh_period <= legal_period;
            sh_ph2    <= cfg_phase2;
            sh_ph3    <= cfg_phase3;
            sh_ph4    <= cfg_phase4;
            sh_half   <= cfg_half_rate;
            sh_par    <= cfg_parallel;
        end
    end

    // Working bank: follows the shadow bank only at safe points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_period <= RST_PERIOD;
            act_ph2    <= RST_PH2;
            act_ph3    <= RST_PH3;
            act_ph4    <= RST_PH4;
            act_half   <= '0;
            act_par    <= 1'b0;
        end else if (load) begin
            act_period <= sh_period;
            act_ph2    <= sh_ph2;
            act_ph3    <= sh_ph3;
            act_ph4    <= sh_ph4;
            act_half   <= sh_half;
            act_par    <= sh_par;
        end
    end
endmodule

// File: rtl/mpc_timebase.sv
// Shared period counter. It counts 0..period-1 while running and toggles a
// period parity bit at each wrap. Assumes period >= 8. `load` marks the
// cycles in which the working configuration may change.
module mpc_timebase #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             run_q,
    output logic             parity,
    output logic             load
);
    logic last;

    // Final cycle of the current period.
    assign last = run_q && (cnt == period - 1'b1);
    // Configuration may change at a period end or while stopped.
    assign load = !run_q || last;

    // Counter, run flag and period parity.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            cnt    <= '0;
            run_q  <= 1'b0;
            parity <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (last) begin
                cnt    <= '0;
                parity <= ~parity;
            end else if (run_q) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mpc_phase_lane.sv
// One channel's start decoder: fires when the shared count reaches the
// channel's slot, lag + sel quarters. Assumes lag + 3 quarters < period, so no
// modulo is needed. A half-rate lane fires only in even periods.
module mpc_phase_lane
    import mpc_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] quarter,
    input  logic [CNT_W-1:0] lag,
    input  quad_t            sel,
    input  logic             half_en,
    input  logic             parity,
    input  logic             run_q,
    output logic             start
);
    logic [CNT_W-1:0] offset;

    // Quarter-step offset chosen by the phase field.
    always_comb begin
        case (sel)
            QUAD_0:   offset = '0;
            QUAD_90:  offset = quarter;
            QUAD_180: offset = quarter << 1;
            default:  offset = quarter + (quarter << 1);
        endcase
    end

    // Start pulse in the matching cycle, skipped in odd periods at half rate.
    assign start = run_q && (cnt == lag + offset) && (!half_en || !parity);
endmodule

// File: rtl/mpc_clkgen.sv
// Top of the multiphase switching clock generator. It joins the configuration
// banks, the shared timebase and one phase lane per channel, and produces the
// 50% synchronization clock. Assumes a single clock domain.
module mpc_clkgen
    import mpc_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int DEF_PERIOD = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              cfg_wr,
    input  logic [CNT_W-1:0]  cfg_period,
    input  logic [1:0]        cfg_phase2,
    input  logic [1:0]        cfg_phase3,
    input  logic [1:0]        cfg_phase4,
    input  logic [3:0]        cfg_half_rate,
    input  logic              cfg_parallel,
    output logic [3:0]        chan_start,
    output logic              sync_out
);
    logic [CNT_W-1:0]  act_period;
    quad_t             act_ph2, act_ph3, act_ph4;
    logic [NUM_CH-1:0] act_half;
    logic              act_par;
    logic [CNT_W-1:0]  cnt;
    logic              run_q, parity, load;
    logic [CNT_W-1:0]  quarter, half_cnt, lag;
    logic [CNT_W+2:0]  lag_wide;
    quad_t             lane_sel [NUM_CH];

    mpc_cfg_regs #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr        (cfg_wr),
        .cfg_period    (cfg_period),
        .cfg_phase2    (cfg_phase2),
        .cfg_phase3    (cfg_phase3),
        .cfg_phase4    (cfg_phase4),
        .cfg_half_rate (cfg_half_rate),
        .cfg_parallel  (cfg_parallel),
        .load          (load),
        .act_period    (act_period),
        .act_ph2       (act_ph2),
        .act_ph3       (act_ph3),
        .act_ph4       (act_ph4),
        .act_half      (act_half),
        .act_par       (act_par)
    );

    mpc_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .period (act_period),
        .cnt    (cnt),
        .run_q  (run_q),
        .parity (parity),
        .load   (load)
    );

    // Derived slot sizes: quarter, half, and the channel 1 lag of 5/32 period.
    assign quarter  = {2'b00, act_period[CNT_W-1:2]};
    assign half_cnt = {1'b0, act_period[CNT_W-1:1]};
    assign lag_wide = ({3'b000, act_period} << 2) + {3'b000, act_period};
    assign lag      = {2'b00, lag_wide[CNT_W+2:5]};

    // Phase selection per lane; paralleling pins channel 2 at half a period.
    assign lane_sel[0] = QUAD_0;
    assign lane_sel[1] = act_par ? QUAD_180 : act_ph2;
    assign lane_sel[2] = act_ph3;
    assign lane_sel[3] = act_ph4;

    // Synchronization clock: high during the first half of each period.
    assign sync_out = run_q && (cnt < half_cnt);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        mpc_phase_lane #(.CNT_W(CNT_W)) u_lane (
            .cnt     (cnt),
            .quarter (quarter),
            .lag     (lag),
            .sel     (lane_sel[g]),
            .half_en (act_half[g]),
            .parity  (parity),
            .run_q   (run_q),
            .start   (chan_start[g])
        );
    end
endmodule

// File: rtl/mpc_clkgen_chk.sv
// Property checker for mpc_clkgen, attached by bind. It measures each high
// phase of the synchronization clock against half the working period.
module mpc_clkgen_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic [3:0]       chan_start,
    input logic             sync_out,
    input logic [CNT_W-1:0] half_cnt
);
    logic [CNT_W-1:0] hi_len;

    // Length of the current high phase of the synchronization clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !sync_out) hi_len <= '0;
        else                     hi_len <= hi_len + 1'b1;
    end

    // R10
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (chan_start == 4'b0000 && !sync_out));

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_start != 4'b0000) |=> ((chan_start & $past(chan_start)) == 4'b0000));

    // R4
    ch1_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_start[0] |-> sync_out);

    // R3
    sync_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sync_out) && $past(run_en)) |-> (hi_len == half_cnt));
endmodule

bind mpc_clkgen mpc_clkgen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .chan_start (chan_start),
    .sync_out   (sync_out),
    .half_cnt   (half_cnt)
);

// File: tb/mpc_clkgen_test.sv
// Sweeping bench: expected pulse slots are computed arithmetically per cycle.
module mpc_clkgen_test;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n, run_en, cfg_wr, cfg_parallel;
    logic [W-1:0] cfg_period;
    logic [1:0]   cfg_phase2, cfg_phase3, cfg_phase4;
    logic [3:0]   cfg_half_rate;
    logic [3:0]   chan_start;
    logic         sync_out;

    int errs = 0;
    int checks = 0;
    int bN, c, p;
    int bq [4];
    logic [3:0] bdiv;
    logic bpar;
    int nN, pend;
    int nq [4];
    logic [3:0] ndiv;
    logic npar;

    always #5 clk = ~clk;

    mpc_clkgen #(.CNT_W(W), .DEF_PERIOD(40)) uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_wr(cfg_wr),
        .cfg_period(cfg_period), .cfg_phase2(cfg_phase2), .cfg_phase3(cfg_phase3),
        .cfg_phase4(cfg_phase4), .cfg_half_rate(cfg_half_rate),
        .cfg_parallel(cfg_parallel), .chan_start(chan_start), .sync_out(sync_out)
    );

    function automatic int legal(input int v);
        int a;
        a = (v / 4) * 4;
        return (a < 8) ? 8 : a;
    endfunction

    task automatic check(input string tag, input logic [3:0] es, input logic esy);
        checks++;
        if (chan_start !== es || sync_out !== esy) begin
            errs++;
            $display("FAIL %s: start=%b sync=%b expected start=%b sync=%b (N=%0d c=%0d p=%0d)",
                     tag, chan_start, sync_out, es, esy, bN, c, p);
        end
    endtask

    task automatic set_pins(input int per, input int q2, input int q3, input int q4,
                            input logic [3:0] dv, input logic pr);
        cfg_period    = W'(per);
        cfg_phase2    = 2'(q2);
        cfg_phase3    = 2'(q3);
        cfg_phase4    = 2'(q4);
        cfg_half_rate = dv;
        cfg_parallel  = pr;
    endtask

    // Write while stopped; the bench model follows at once.
    task automatic cfg_idle(input int per, input int q2, input int q3, input int q4,
                            input logic [3:0] dv, input logic pr);
        set_pins(per, q2, q3, q4, dv, pr);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        bN = legal(per); bq[1] = q2; bq[2] = q3; bq[3] = q4; bdiv = dv; bpar = pr;
    endtask

    task automatic start_run();
        run_en = 1'b1;
        c = 0; p = 0; pend = 0;
    endtask

    // Sample each cycle; optionally strobe a pending write at index wr_at.
    task automatic run_cycles(input string tag, input int n, input int wr_at);
        for (int i = 0; i < n; i++) begin
            logic [3:0] es;
            int lagv, q;
            @(negedge clk);
            if (i == wr_at + 1) cfg_wr = 1'b0;
            lagv = (bN * 5) / 32;
            for (int k = 0; k < 4; k++) begin
                q = (k == 0) ? 0 : ((k == 1 && bpar) ? 2 : bq[k]);
                es[k] = (c == lagv + q * (bN / 4)) && (!bdiv[k] || (p % 2 == 0));
            end
            check(tag, es, c < bN / 2);
            if (i == wr_at) begin
                cfg_wr = 1'b1;
                pend = 1;
            end
            c++;
            if (c == bN) begin
                c = 0; p++;
                if (pend != 0) begin
                    bN = nN; bq[1] = nq[1]; bq[2] = nq[2]; bq[3] = nq[3];
                    bdiv = ndiv; bpar = npar; pend = 0;
                end
            end
        end
        cfg_wr = 1'b0;
    endtask

    task automatic stop_run(input string tag);
        run_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(tag, 4'b0000, 1'b0);
        end
    endtask

    initial begin
        #1_500_000;
        errs++;
        $display("FAIL watchdog: R10 run did not complete, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        bq[0] = 0; nq[0] = 0;
        rst_n = 1'b0; run_en = 1'b0; cfg_wr = 1'b0;
        set_pins(0, 0, 0, 0, 4'b0000, 1'b0);
        bN = 40;
        // R1: quiet during reset and after release while stopped
        repeat (3) begin
            @(negedge clk);
            check("R1", 4'b0000, 1'b0);
        end
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R1", 4'b0000, 1'b0);
        end

        // R6: defaults with no write (period 40, q = 2/1/3)
        bN = 40; bq[1] = 2; bq[2] = 1; bq[3] = 3; bdiv = 4'b0000; bpar = 1'b0;
        start_run();
        run_cycles("R6", 120, -5);
        stop_run("R10");

        // R2: raw period values that need rounding or raising
        foreach (bq[k]) begin end
        for (int j = 0; j < 8; j++) begin
            int pv;
            case (j)
                0: pv = 8;  1: pv = 9;  2: pv = 5;  3: pv = 15;
                4: pv = 20; 5: pv = 33; 6: pv = 64; default: pv = 101;
            endcase
            cfg_idle(pv, 1, 2, 3, 4'b0000, 1'b0);
            start_run();
            run_cycles("R2", 3 * legal(pv), -5);
            stop_run("R10");
        end

        // R5 and R4: every phase combination at two periods
        for (int nsel = 0; nsel < 2; nsel++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    for (int d = 0; d < 4; d++) begin
                        cfg_idle(nsel == 0 ? 16 : 28, a, b, d, 4'b0000, 1'b0);
                        start_run();
                        run_cycles("R5", 2 * bN, -5);
                        stop_run("R10");
                    end
                end
            end
        end

        // R7: paralleling overrides every channel 2 field
        for (int a = 0; a < 4; a++) begin
            cfg_idle(20, a, 3, 1, 4'b0000, 1'b1);
            start_run();
            run_cycles("R7", 60, -5);
            stop_run("R10");
        end

        // R8: every half-rate mask over four periods
        for (int m = 0; m < 16; m++) begin
            cfg_idle(12, 1, 2, 3, 4'(m), 1'b0);
            start_run();
            run_cycles("R8", 48, -5);
            stop_run("R10");
        end

        // R9: a write while running lands at the next period boundary
        cfg_idle(16, 1, 2, 3, 4'b0000, 1'b0);
        start_run();
        set_pins(24, 3, 0, 1, 4'b0010, 1'b0);
        nN = 24; nq[1] = 3; nq[2] = 0; nq[3] = 1; ndiv = 4'b0010; npar = 1'b0;
        run_cycles("R9", 16 + 24 * 3, 3);

        // R10: stop mid-period, then restart from period 0 cycle 0
        set_pins(24, 3, 0, 1, 4'b0010, 1'b0);
        run_cycles("R9", 7, -5);
        stop_run("R10");
        start_run();
        run_cycles("R10", 72, -5);
        stop_run("R10");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule